// File: doc/BRIEF.md
# Hardware Cursor Overlay Mixer

This block lays a 64 by 64 pixel hardware cursor over an indexed-colour background, one pixel per clock. For each raster pixel it compares the raster coordinate against the cursor origin. When the pixel lies inside the cursor window, it reads a 2-bit code from an external cursor pattern RAM. Code zero lets the background colour through. Any other code picks one of three cursor colours.

Each raster pixel is presented with its background RGB. The block drives the pattern RAM address in the same cycle. The RAM answers one clock later, so the background colour and the window decision travel through one register stage. Each final pixel therefore appears one cycle after its input. The cursor origin comes from a single packed position word, and a disable input removes the cursor from the picture entirely.

Top module: `cursor_overlay_mixer`

## Requirements
- R1: While rst_ni is low, and in every cycle after reset in which rgb_valid_o is low, rgb_o is zero; rgb_valid_o is low during reset.
- R2: rgb_valid_o equals pix_valid_i delayed by one clock, and the colour for a pixel presented in cycle N appears on rgb_o in cycle N+1.
- R3: The cursor origin column is cur_pos_i[23:12] and the origin row is cur_pos_i[11:0].
- R4: A pixel is in the cursor window only when 0 <= x - origin_x < 64 and 0 <= y - origin_y < 64, with the differences taken as true signed values. A pixel to the left of or above the origin is outside the window, including when the 12-bit subtraction would wrap. Pixels outside the window output bg_rgb_i.
- R5: For a pixel inside the window, pat_addr_o equals row_offset*8 + column_offset/8 in the same cycle the pixel is presented, and pat_data_i is taken to hold that word one clock later.
- R6: The pixel's 2-bit code is bits [2*(column_offset mod 8)+1 : 2*(column_offset mod 8)] of the pattern word.
- R7: Code 0 outputs the background colour. Codes 1, 2 and 3 output cursor palette entry code-1, where entry k is cur_pal_i[24k+23:24k] laid out as {red[7:0], green[7:0], blue[7:0]}.
- R8: While cur_off_i is high, every pixel outputs bg_rgb_i, whatever its position or the pattern contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_valid_i | input | 1 | Raster pixel present this cycle |
| raster_x_i | input | 12 | Raster column |
| raster_y_i | input | 12 | Raster row |
| cur_pos_i | input | 24 | Cursor origin, column in [23:12], row in [11:0] |
| cur_off_i | input | 1 | Cursor disable |
| bg_rgb_i | input | 24 | Background colour for this pixel |
| cur_pal_i | input | 72 | Three cursor colours, entry k at [24k+23:24k] |
| pat_addr_o | output | 9 | Pattern RAM word address |
| pat_data_i | input | 16 | Pattern RAM word, one clock after the address |
| rgb_o | output | 24 | Final pixel colour |
| rgb_valid_o | output | 1 | rgb_o holds a pixel |

## Verification
Directed pixels sit exactly on the four window edges and one step outside each. This separates an off-by-one at the far edge from a missing check of the near edge. An origin at the top of the coordinate range with the raster near zero exposes a window test that trusts a wrapped unsigned difference. A pattern word holding every code in turn across its eight pixels fixes the bit order within the word and the mapping from code to palette entry. Random origins and nearby raster points, with random pattern and palette contents, then cover row and column address arithmetic across many words, while bubbles and disable cycles separate the valid path from the colour path.

// File: rtl/cur_mix_pkg.sv
package cur_mix_pkg;
  localparam int RGB_W = 24;
  typedef logic [RGB_W-1:0] rgb_t;
endpackage

// File: rtl/cur_win_calc.sv
module cur_win_calc #(
  parameter int COORD_W      = 12,
  parameter int CUR_DIM      = 64,
  parameter int PIX_PER_WORD = 8,
  localparam int OFF_W       = $clog2(CUR_DIM),
  localparam int SUB_W       = $clog2(PIX_PER_WORD),
  localparam int ADDR_W      = 2*OFF_W - SUB_W
) (
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [COORD_W-1:0] org_x_i,
  input  logic [COORD_W-1:0] org_y_i,
  input  logic               off_i,
  output logic               hit_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [SUB_W-1:0]   sub_o
);
  // one extra bit keeps the borrow, so a negative offset never looks small
  logic [COORD_W:0] dx, dy;
  logic hit_x, hit_y;

  always_comb begin
    dx    = {1'b0, x_i} - {1'b0, org_x_i};
    dy    = {1'b0, y_i} - {1'b0, org_y_i};
    hit_x = dx < (COORD_W+1)'(CUR_DIM);
    hit_y = dy < (COORD_W+1)'(CUR_DIM);
    hit_o = hit_x && hit_y && !off_i;
    addr_o = {dy[OFF_W-1:0], dx[OFF_W-1:SUB_W]};
    sub_o  = dx[SUB_W-1:0];
  end
endmodule

// File: rtl/cur_code_sel.sv
module cur_code_sel #(
  parameter int PIX_PER_WORD = 8,
  parameter int CODE_W       = 2,
  localparam int WORD_W      = PIX_PER_WORD*CODE_W,
  localparam int SUB_W       = $clog2(PIX_PER_WORD)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [SUB_W-1:0]  sub_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] slot [PIX_PER_WORD];

  for (genvar g = 0; g < PIX_PER_WORD; g++) begin : g_slot
    assign slot[g] = word_i[g*CODE_W +: CODE_W];
  end

  assign code_o = slot[sub_i];
endmodule

// File: rtl/cur_color_mux.sv
module cur_color_mux
  import cur_mix_pkg::*;
#(
  parameter int CODE_W   = 2,
  localparam int N_COL   = (1 << CODE_W) - 1
) (
  input  rgb_t              bg_i,
  input  rgb_t              pal_i [N_COL],
  input  logic              hit_i,
  input  logic [CODE_W-1:0] code_i,
  output rgb_t              rgb_o
);
  always_comb begin
    rgb_o = bg_i;
    if (hit_i && code_i != '0) rgb_o = pal_i[code_i - CODE_W'(1)];
  end
endmodule

// File: rtl/cursor_overlay_mixer.sv
module cursor_overlay_mixer
  import cur_mix_pkg::*;
#(
  parameter int COORD_W      = 12,
  parameter int CUR_DIM      = 64,
  parameter int PIX_PER_WORD = 8,
  parameter int CODE_W       = 2,
  localparam int OFF_W       = $clog2(CUR_DIM),
  localparam int SUB_W       = $clog2(PIX_PER_WORD),
  localparam int ADDR_W      = 2*OFF_W - SUB_W,
  localparam int WORD_W      = PIX_PER_WORD*CODE_W,
  localparam int N_COL       = (1 << CODE_W) - 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pix_valid_i,
  input  logic [COORD_W-1:0]     raster_x_i,
  input  logic [COORD_W-1:0]     raster_y_i,
  input  logic [2*COORD_W-1:0]   cur_pos_i,
  input  logic                   cur_off_i,
  input  logic [RGB_W-1:0]       bg_rgb_i,
  input  logic [N_COL*RGB_W-1:0] cur_pal_i,
  output logic [ADDR_W-1:0]      pat_addr_o,
  input  logic [WORD_W-1:0]      pat_data_i,
  output logic [RGB_W-1:0]       rgb_o,
  output logic                   rgb_valid_o
);
  logic [COORD_W-1:0] org_x, org_y;
  logic               hit;
  logic [SUB_W-1:0]   sub;
  logic               valid_q, hit_q, past_ok_q;
  logic [SUB_W-1:0]   sub_q;
  rgb_t               bg_q, mix_rgb;
  logic [CODE_W-1:0]  code;
  rgb_t               pal [N_COL];

  assign org_x = cur_pos_i[2*COORD_W-1:COORD_W];
  assign org_y = cur_pos_i[COORD_W-1:0];

  for (genvar k = 0; k < N_COL; k++) begin : g_pal
    assign pal[k] = cur_pal_i[k*RGB_W +: RGB_W];
  end

  cur_win_calc #(
    .COORD_W(COORD_W), .CUR_DIM(CUR_DIM), .PIX_PER_WORD(PIX_PER_WORD)
  ) u_win (
    .x_i(raster_x_i), .y_i(raster_y_i), .org_x_i(org_x), .org_y_i(org_y),
    .off_i(cur_off_i), .hit_o(hit), .addr_o(pat_addr_o), .sub_o(sub)
  );

  // stage 1 aligns with the registered pattern RAM read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      hit_q     <= 1'b0;
      sub_q     <= '0;
      bg_q      <= '0;
      past_ok_q <= 1'b0;
    end else begin
      valid_q   <= pix_valid_i;
      hit_q     <= pix_valid_i && hit;
      sub_q     <= sub;
      bg_q      <= bg_rgb_i;
      past_ok_q <= 1'b1;
    end
  end

  cur_code_sel #(
    .PIX_PER_WORD(PIX_PER_WORD), .CODE_W(CODE_W)
  ) u_code (
    .word_i(pat_data_i), .sub_i(sub_q), .code_o(code)
  );

  cur_color_mux #(
    .CODE_W(CODE_W)
  ) u_mux (
    .bg_i(bg_q), .pal_i(pal), .hit_i(hit_q), .code_i(code), .rgb_o(mix_rgb)
  );

  assign rgb_valid_o = valid_q;
  assign rgb_o       = valid_q ? mix_rgb : '0;

  // R2
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> rgb_valid_o == $past(pix_valid_i));

  // R1
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !$past(pix_valid_i)) |-> rgb_o == '0);

  // R8
  off_passes_bg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && cur_off_i) |=> (rgb_valid_o && rgb_o == $past(bg_rgb_i)));

  // R4
  hit_not_before_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && hit) |-> (raster_x_i >= org_x && raster_y_i >= org_y));

  // R7
  transparent_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && rgb_valid_o && code == '0) |-> rgb_o == $past(bg_rgb_i));
endmodule

// File: tb/tb_cursor_overlay_mixer.sv
`timescale 1ns/1ps
module tb_cursor_overlay_mixer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic [11:0] rx = '0, ry = '0;
  logic [23:0] pos = '0;
  logic        off = 1'b0;
  logic [23:0] bg = '0;
  logic [71:0] pal = '0;
  logic [8:0]  pat_addr;
  logic [15:0] pat_q = '0;
  logic [23:0] rgb;
  logic        rgb_valid;
  logic [15:0] mem [512];

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cursor_overlay_mixer dut (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(pix_valid),
    .raster_x_i(rx), .raster_y_i(ry), .cur_pos_i(pos), .cur_off_i(off),
    .bg_rgb_i(bg), .cur_pal_i(pal), .pat_addr_o(pat_addr),
    .pat_data_i(pat_q), .rgb_o(rgb), .rgb_valid_o(rgb_valid)
  );

  always @(posedge clk) pat_q <= mem[pat_addr];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit in_win(input int x, input int y, input logic [23:0] p, input bit o);
    int dx = x - int'(p[23:12]);
    int dy = y - int'(p[11:0]);
    return !o && dx >= 0 && dx < 64 && dy >= 0 && dy < 64;
  endfunction

  function automatic logic [23:0] exp_rgb(input int x, input int y, input logic [23:0] p,
                                          input bit o, input logic [23:0] b);
    int dx = x - int'(p[23:12]);
    int dy = y - int'(p[11:0]);
    logic [15:0] w;
    logic [1:0] c;
    if (!in_win(x, y, p, o)) return b;
    w = mem[dy*8 + dx/8];
    c = w[(dx%8)*2 +: 2];
    if (c == 2'd0) return b;
    return pal[(int'(c)-1)*24 +: 24];
  endfunction

  // drive at a negedge, check the address, then check the colour one clock later
  task automatic pixel(input int x, input int y, input logic [23:0] p, input bit o,
                       input logic [23:0] b, input string req);
    logic [23:0] e;
    rx = 12'(x); ry = 12'(y); pos = p; off = o; bg = b; pix_valid = 1'b1;
    #1;
    if (in_win(x, y, p, o))
      chk(pat_addr == 9'((y - int'(p[11:0]))*8 + (x - int'(p[23:12]))/8),
          {"R5 ", req}, 32'(pat_addr),
          32'((y - int'(p[11:0]))*8 + (x - int'(p[23:12]))/8));
    e = exp_rgb(x, y, p, o, b);
    @(posedge clk); @(negedge clk);
    chk(rgb_valid == 1'b1, {"R2 ", req}, 32'(rgb_valid), 32'd1);
    chk(rgb == e, req, 32'(rgb), 32'(e));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 512; i++) mem[i] = 16'($urandom);
    mem[200*0] = 16'hE4E4;
    pal = {24'h0000FF, 24'h00FF00, 24'hFF0000};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rgb_valid == 1'b0, "R1 valid in reset", 32'(rgb_valid), 0);
    chk(rgb == '0, "R1 rgb in reset", 32'(rgb), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rgb == '0 && !rgb_valid, "R1 idle after reset", 32'(rgb), 0);

    // R3 R6 R7: word 0 codes 0,1,2,3,0,1,2,3 at origin (100,200)
    for (int c = 0; c < 8; c++)
      pixel(100 + c, 200, {12'd100, 12'd200}, 1'b0, 24'hABCDEF, "R6 R7 code order");
    // R4 edges
    pixel(99, 200, {12'd100, 12'd200}, 1'b0, 24'h111111, "R4 left of origin");
    pixel(100, 199, {12'd100, 12'd200}, 1'b0, 24'h222222, "R4 above origin");
    pixel(163, 263, {12'd100, 12'd200}, 1'b0, 24'h333333, "R4 far corner inside");
    pixel(164, 230, {12'd100, 12'd200}, 1'b0, 24'h444444, "R4 right of window");
    pixel(130, 264, {12'd100, 12'd200}, 1'b0, 24'h555555, "R4 below window");
    pixel(0, 0, {12'd4095, 12'd4095}, 1'b0, 24'h666666, "R4 wrapped negative offset");
    pixel(4095, 4095, {12'd4060, 12'd4090}, 1'b0, 24'h777777, "R3 top of range inside");
    // R8 disable inside window
    for (int c = 0; c < 8; c++)
      pixel(101 + c, 201, {12'd100, 12'd200}, 1'b1, 24'h0F0F0F, "R8 cursor off");
    // R1 R2 bubble
    pix_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(rgb_valid == 1'b0, "R2 bubble valid", 32'(rgb_valid), 0);
    chk(rgb == '0, "R1 bubble rgb", 32'(rgb), 0);

    // random pixels near random origins
    pal = {24'($urandom), 24'($urandom), 24'($urandom)};
    for (int i = 0; i < 3000; i++) begin
      logic [23:0] p = 24'($urandom);
      int x = (int'(p[23:12]) + int'($urandom_range(0, 79)) - 8) & 12'hFFF;
      int y = (int'(p[11:0])  + int'($urandom_range(0, 79)) - 8) & 12'hFFF;
      pixel(x, y, p, ($urandom_range(0, 9) == 0), 24'($urandom), "R4 R5 R6 R7 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule